// File: doc/BRIEF.md
# Configurable Block Chaining Datapath

This block wraps an external 128-bit block-cipher core and turns it into a chaining-mode engine. It does not fix the mode. A 32-bit mode word sets four separate things: what the core is fed, where the XOR points sit, which vector is XORed, and which value starts a message. From these fields the same datapath gives electronic codebook, cipher block chaining in both directions, counter mode, tweaked mode with an externally supplied tweak, and a chained MAC.

Data blocks arrive on a valid/ready stream and results leave on a second valid/ready stream. The cipher work is handed to the outside core over a request/response pair, and the request carries the wanted direction. Only one block is in flight at a time. The mode word is sampled when a block is accepted. A block that carries `in_last` closes its message, so the next accepted block starts a new one.

Top module: `chain_datapath`

## Requirements
- R1: After reset `in_ready` is 1, `out_valid` and `core_req_valid` are 0, and the next block starts a new message.
- R2: Mode bits [4:3] pick the word the core is fed: 0 the incoming block, 1 a free-running pseudo-random value, 2 the previous raw core output, 3 the counter register.
- R3: Mode bits [2:1] place the XOR: 0 none, 1 before and after the core, 2 before the core only, 3 after the core only.
- R4: Mode bits [6:5] pick the XOR vector: 0 the incoming block, 1 the `tweak` port, 2 and 3 the vector register. After each block that register takes the raw core output, or the incoming block when the field is 3.
- R5: On the first block of a message, mode bits [8:7] seed both the vector and the counter register: 2 from the IV register (written by `iv_load`), 3 from the pseudo-random value, 0 or 1 keeps the value left over from the previous message.
- R6: Mode bit 9 drives `core_req_enc` (1 encrypt, 0 decrypt). With matching modes, ECB and CBC encryption followed by decryption return the plaintext.
- R7: After each block the counter register advances by the unsigned value of mode bits [18:11], modulo 2^128. Counter mode (fed from the counter, XOR after the core, vector = block, step 1) run twice returns the original data.
- R8: When mode bit 0 is set, no result is emitted for a block unless it is the last block of its message. The emitted result is the final chained value.
- R9: `out_last` equals the `in_last` of the block that produced the result.
- R10: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold. While `core_req_valid` is high and `core_req_ready` is low, the request holds. At most one of `in_ready`, `core_req_valid` and `out_valid` is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_word | input | 32 | Mode word, sampled when a block is accepted |
| iv_load | input | 1 | Write `iv_value` into the IV register |
| iv_value | input | 128 | IV / initial counter value |
| tweak | input | 128 | Tweak vector, sampled with the block |
| in_valid | input | 1 | Input block valid |
| in_ready | output | 1 | Ready for an input block |
| in_data | input | 128 | Input block |
| in_last | input | 1 | Block closes its message |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result accepted |
| out_data | output | 128 | Result block |
| out_last | output | 1 | Result belongs to a last block |
| core_req_valid | output | 1 | Request to the cipher core |
| core_req_ready | input | 1 | Core accepts the request |
| core_req_data | output | 128 | Word fed to the core |
| core_req_enc | output | 1 | 1 encrypt, 0 decrypt |
| core_rsp_valid | input | 1 | Core result valid |
| core_rsp_data | input | 128 | Core result |

## Verification
The bench goes after the chaining state across block and message boundaries. A design that seeded the vector on every block, or never reseeded it, breaks the CBC round trip and the continued-IV message. A counter that saturated or added a fixed 1 fails the all-ones wrap test and the step-5 test. A MAC mode that leaked intermediate blocks, or reported the post-XOR word from the wrong vector, shows up as a stray output or a wrong tag. Random mode words, backpressure on both the core and the output, and a feedback mode that feeds the previous core output expose any mix-up in the select fields.

// File: rtl/cdp_pkg.sv
package cdp_pkg;

  localparam int MODE_W = 32;
  localparam int STEP_W = 8;

  typedef enum logic [1:0] {SRC_BLOCK = 2'd0, SRC_RAND = 2'd1, SRC_PREV_OUT = 2'd2, SRC_COUNTER = 2'd3} in_src_e;
  typedef enum logic [1:0] {XP_NONE = 2'd0, XP_BOTH = 2'd1, XP_PRE = 2'd2, XP_POST = 2'd3} xor_pos_e;
  typedef enum logic [1:0] {VS_BLOCK = 2'd0, VS_TWEAK = 2'd1, VS_CHAIN = 2'd2, VS_PREV_IN = 2'd3} vec_src_e;
  typedef enum logic [1:0] {IVS_KEEP0 = 2'd0, IVS_KEEP = 2'd1, IVS_REG = 2'd2, IVS_RAND = 2'd3} iv_src_e;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_OUT} state_e;

  typedef struct packed {
    logic [STEP_W-1:0] step;
    logic              enc;
    iv_src_e           iv_src;
    vec_src_e          vec_src;
    in_src_e           in_src;
    xor_pos_e          xpos;
    logic              mac;
  } mode_t;

  function automatic mode_t decode_mode(input logic [MODE_W-1:0] w);
    mode_t m;
    m.mac     = w[0];
    m.xpos    = xor_pos_e'(w[2:1]);
    m.in_src  = in_src_e'(w[4:3]);
    m.vec_src = vec_src_e'(w[6:5]);
    m.iv_src  = iv_src_e'(w[8:7]);
    m.enc     = w[9];
    m.step    = w[18:11];
    return m;
  endfunction

endpackage

// File: rtl/cdp_lfsr.sv
module cdp_lfsr #(
  parameter int W = 128,
  parameter int TAP_A = 125,
  parameter int TAP_B = 100,
  parameter int TAP_C = 98,
  parameter logic [W-1:0] SEED = {W{1'b1}}
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] value
);
  logic fb;
  assign fb = value[W-1] ^ value[TAP_A] ^ value[TAP_B] ^ value[TAP_C];

  always_ff @(posedge clk) begin
    if (rst) value <= SEED;
    else     value <= {value[W-2:0], fb};
  end
endmodule

// File: rtl/cdp_front.sv
module cdp_front
  import cdp_pkg::*;
#(
  parameter int BLK_W = 128
) (
  input  in_src_e          in_src,
  input  xor_pos_e         xpos,
  input  vec_src_e         vec_src,
  input  iv_src_e          iv_src,
  input  logic             first,
  input  logic [BLK_W-1:0] blk,
  input  logic [BLK_W-1:0] tweak,
  input  logic [BLK_W-1:0] rnd,
  input  logic [BLK_W-1:0] vec_reg,
  input  logic [BLK_W-1:0] ctr_reg,
  input  logic [BLK_W-1:0] iv_reg,
  input  logic [BLK_W-1:0] prev_out,
  output logic [BLK_W-1:0] vec_cur,
  output logic [BLK_W-1:0] ctr_cur,
  output logic [BLK_W-1:0] xvec,
  output logic [BLK_W-1:0] pre
);
  logic [BLK_W-1:0] base;

  always_comb begin
    vec_cur = vec_reg;
    ctr_cur = ctr_reg;
    if (first) begin
      case (iv_src)
        IVS_REG:  begin vec_cur = iv_reg; ctr_cur = iv_reg; end
        IVS_RAND: begin vec_cur = rnd;    ctr_cur = rnd;    end
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (vec_src)
      VS_BLOCK: xvec = blk;
      VS_TWEAK: xvec = tweak;
      default:  xvec = vec_cur;
    endcase
  end

  always_comb begin
    case (in_src)
      SRC_BLOCK:    base = blk;
      SRC_RAND:     base = rnd;
      SRC_PREV_OUT: base = prev_out;
      default:      base = ctr_cur;
    endcase
  end

  assign pre = (xpos == XP_BOTH || xpos == XP_PRE) ? (base ^ xvec) : base;
endmodule

// File: rtl/cdp_back.sv
module cdp_back
  import cdp_pkg::*;
#(
  parameter int BLK_W = 128
) (
  input  xor_pos_e          xpos,
  input  vec_src_e          vec_src,
  input  logic [STEP_W-1:0] step,
  input  logic [BLK_W-1:0]  core_out,
  input  logic [BLK_W-1:0]  xvec,
  input  logic [BLK_W-1:0]  blk,
  input  logic [BLK_W-1:0]  ctr_cur,
  output logic [BLK_W-1:0]  result,
  output logic [BLK_W-1:0]  vec_next,
  output logic [BLK_W-1:0]  ctr_next
);
  assign result   = (xpos == XP_BOTH || xpos == XP_POST) ? (core_out ^ xvec) : core_out;
  assign vec_next = (vec_src == VS_PREV_IN) ? blk : core_out;
  assign ctr_next = ctr_cur + BLK_W'(step);
endmodule

// File: rtl/chain_datapath.sv
module chain_datapath
  import cdp_pkg::*;
#(
  parameter int BLK_W = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode_word,
  input  logic              iv_load,
  input  logic [BLK_W-1:0]  iv_value,
  input  logic [BLK_W-1:0]  tweak,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BLK_W-1:0]  in_data,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BLK_W-1:0]  out_data,
  output logic              out_last,
  output logic              core_req_valid,
  input  logic              core_req_ready,
  output logic [BLK_W-1:0]  core_req_data,
  output logic              core_req_enc,
  input  logic              core_rsp_valid,
  input  logic [BLK_W-1:0]  core_rsp_data
);
  state_e           state;
  mode_t            mode_live, mode_q;
  logic             first_q, last_q;
  logic [BLK_W-1:0] blk_q, xvec_q, vec_reg, ctr_reg, iv_reg, prev_out, rnd;
  logic [BLK_W-1:0] vec_cur, ctr_cur, xvec, pre, result, vec_next, ctr_next;
  logic             mac_q;
  logic             unused_bits;

  assign mode_live   = decode_mode(mode_word);
  assign mac_q       = mode_q.mac;
  assign unused_bits = ^{mode_word[31:19], mode_word[10], mode_q.in_src, mode_q.iv_src};

  cdp_lfsr #(.W(BLK_W)) u_rand (.clk(clk), .rst(rst), .value(rnd));

  cdp_front #(.BLK_W(BLK_W)) u_front (
    .in_src(mode_live.in_src), .xpos(mode_live.xpos), .vec_src(mode_live.vec_src),
    .iv_src(mode_live.iv_src), .first(first_q), .blk(in_data), .tweak(tweak), .rnd(rnd),
    .vec_reg(vec_reg), .ctr_reg(ctr_reg), .iv_reg(iv_reg), .prev_out(prev_out),
    .vec_cur(vec_cur), .ctr_cur(ctr_cur), .xvec(xvec), .pre(pre)
  );

  cdp_back #(.BLK_W(BLK_W)) u_back (
    .xpos(mode_q.xpos), .vec_src(mode_q.vec_src), .step(mode_q.step),
    .core_out(core_rsp_data), .xvec(xvec_q), .blk(blk_q), .ctr_cur(ctr_reg),
    .result(result), .vec_next(vec_next), .ctr_next(ctr_next)
  );

  assign in_ready       = (state == ST_IDLE);
  assign core_req_valid = (state == ST_REQ);
  assign out_valid      = (state == ST_OUT);
  assign core_req_enc   = mode_q.enc;

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      mode_q        <= '0;
      first_q       <= 1'b1;
      last_q        <= 1'b0;
      blk_q         <= '0;
      xvec_q        <= '0;
      vec_reg       <= '0;
      ctr_reg       <= '0;
      iv_reg        <= '0;
      prev_out      <= '0;
      core_req_data <= '0;
      out_data      <= '0;
      out_last      <= 1'b0;
    end else begin
      if (iv_load) iv_reg <= iv_value;
      case (state)
        ST_IDLE: if (in_valid) begin
          mode_q        <= mode_live;
          blk_q         <= in_data;
          last_q        <= in_last;
          xvec_q        <= xvec;
          vec_reg       <= vec_cur;
          ctr_reg       <= ctr_cur;
          core_req_data <= pre;
          state         <= ST_REQ;
        end
        ST_REQ: if (core_req_ready) state <= ST_WAIT;
        ST_WAIT: if (core_rsp_valid) begin
          vec_reg  <= vec_next;
          ctr_reg  <= ctr_next;
          prev_out <= core_rsp_data;
          first_q  <= last_q;
          out_data <= result;
          out_last <= last_q;
          state    <= (!mode_q.mac || last_q) ? ST_OUT : ST_IDLE;
        end
        default: if (out_ready) state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cdp_checker.sv
module cdp_checker #(
  parameter int BLK_W = 128
) (
  input logic             clk,
  input logic             rst,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [BLK_W-1:0] out_data,
  input logic             out_last,
  input logic             core_req_valid,
  input logic             core_req_ready,
  input logic [BLK_W-1:0] core_req_data,
  input logic             core_req_enc,
  input logic             mac_q
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    rst_d |-> (in_ready && !out_valid && !core_req_valid));

  p_out_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (core_req_valid && !core_req_ready) |=> (core_req_valid && $stable(core_req_data)));

  p_dir_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (core_req_valid && !core_req_ready) |=> $stable(core_req_enc));

  p_one_stage_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({in_ready, core_req_valid, out_valid}));

  p_mac_last_only_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && mac_q) |-> out_last);
endmodule

bind chain_datapath cdp_checker #(.BLK_W(BLK_W)) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_last(out_last), .core_req_valid(core_req_valid),
  .core_req_ready(core_req_ready), .core_req_data(core_req_data),
  .core_req_enc(core_req_enc), .mac_q(mac_q)
);

// File: tb/sim_chain_datapath.sv
module sim_chain_datapath;
  localparam int CLK_PERIOD = 10;
  localparam logic [127:0] KEY = 128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] mode_word = '0;
  logic iv_load = 1'b0;
  logic [127:0] iv_value = '0, tweak = '0, in_data = '0;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid, out_last, core_req_valid, core_req_enc;
  logic [127:0] out_data, core_req_data;
  logic core_req_ready = 1'b0, core_rsp_valid = 1'b0;
  logic [127:0] core_rsp_data = '0;

  int tests = 0, fails = 0;
  logic [127:0] m_vec = '0, m_ctr = '0, m_iv = '0, m_prev = '0, last_res = '0;
  bit m_first = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  chain_datapath u0 (
    .clk(clk), .rst(rst), .mode_word(mode_word), .iv_load(iv_load), .iv_value(iv_value),
    .tweak(tweak), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .core_req_valid(core_req_valid), .core_req_ready(core_req_ready),
    .core_req_data(core_req_data), .core_req_enc(core_req_enc),
    .core_rsp_valid(core_rsp_valid), .core_rsp_data(core_rsp_data)
  );

  function automatic logic [127:0] enc_f(input logic [127:0] x);
    return {x[122:0], x[127:123]} ^ KEY;
  endfunction
  function automatic logic [127:0] dec_f(input logic [127:0] y);
    logic [127:0] t;
    t = y ^ KEY;
    return {t[4:0], t[127:5]};
  endfunction

  function automatic logic [31:0] mk(input int insel, input int xp, input int vs, input int ivs,
                                     input bit enc, input int step, input bit mac);
    logic [31:0] w;
    w = '0;
    w[0] = mac; w[2:1] = xp[1:0]; w[4:3] = insel[1:0]; w[6:5] = vs[1:0];
    w[8:7] = ivs[1:0]; w[9] = enc; w[18:11] = step[7:0];
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] got, input logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // stand-in cipher core with random acceptance and latency
  initial begin
    bit busy = 1'b0;
    int cnt = 0;
    logic [127:0] res = '0;
    forever begin
      @(negedge clk);
      core_rsp_valid = 1'b0;
      if (busy) begin
        core_req_ready = 1'b0;
        if (cnt == 0) begin
          core_rsp_valid = 1'b1; core_rsp_data = res; last_res = res; busy = 1'b0;
        end else cnt--;
      end else begin
        core_req_ready = ($urandom % 3) != 0;
        if (core_req_valid && core_req_ready) begin
          res = core_req_enc ? enc_f(core_req_data) : dec_f(core_req_data);
          busy = 1'b1; cnt = $urandom % 3;
        end
      end
    end
  end

  task automatic load_iv(input logic [127:0] v);
    @(negedge clk); iv_load = 1'b1; iv_value = v;
    @(negedge clk); iv_load = 1'b0;
    m_iv = v;
  endtask

  // reference model for one block; returns expected result and whether it is emitted
  task automatic model(input logic [31:0] w, input logic [127:0] d, input logic [127:0] tw,
                       input bit last, output logic [127:0] exp, output bit emit);
    logic [127:0] base, xv, pre, r;
    if (m_first && w[8:7] == 2'd2) begin m_vec = m_iv; m_ctr = m_iv; end
    case (w[6:5]) 2'd0: xv = d; 2'd1: xv = tw; default: xv = m_vec; endcase
    case (w[4:3]) 2'd0: base = d; 2'd2: base = m_prev; default: base = m_ctr; endcase
    pre = (w[2:1] == 2'd1 || w[2:1] == 2'd2) ? base ^ xv : base;
    r   = w[9] ? enc_f(pre) : dec_f(pre);
    exp = (w[2:1] == 2'd1 || w[2:1] == 2'd3) ? r ^ xv : r;
    m_vec = (w[6:5] == 2'd3) ? d : r;
    m_ctr = m_ctr + 128'(w[18:11]);
    m_prev = r;
    m_first = last;
    emit = !w[0] || last;
  endtask

  task automatic run_block(input logic [31:0] w, input logic [127:0] d, input logic [127:0] tw,
                           input bit last, input bit use_model, input string req,
                           output logic [127:0] got);
    logic [127:0] exp, held;
    bit emit, bad;
    int n, dly;
    exp = '0; emit = 1'b1;
    if (use_model) model(w, d, tw, last, exp, emit);
    @(negedge clk);
    mode_word = w; in_data = d; tweak = tw; in_last = last; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    got = '0;
    if (emit) begin
      n = 0;
      while (!out_valid && n < 500) begin @(negedge clk); n++; end
      held = out_data;
      dly = $urandom % 3;
      repeat (dly) @(negedge clk);
      if (dly > 0) chk(out_valid && out_data == held, "R10 hold", out_data, held);
      got = out_data;
      if (use_model) chk(out_valid && got == exp, req, got, exp);
      chk(out_last == last, "R9 last flag", 128'(out_last), 128'(last));
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
    end else begin
      n = 0; bad = 1'b0;
      while (!in_ready && n < 500) begin
        @(negedge clk);
        if (out_valid) bad = 1'b1;
        n++;
      end
      chk(!bad, "R8 no mid-message output", 128'(bad), 128'(0));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [127:0] pt [4];
    logic [127:0] ct [4];
    logic [127:0] bk [4];
    logic [127:0] g, g1, g2;
    logic [31:0] w;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(in_ready && !out_valid && !core_req_valid, "R1 reset state",
        {125'd0, in_ready, out_valid, core_req_valid}, 128'd4);

    foreach (pt[i]) pt[i] = {$urandom, $urandom, $urandom, $urandom};

    // R2/R6 ECB encrypt and decrypt round trip
    for (int i = 0; i < 4; i++) run_block(mk(0, 0, 0, 2, 1, 0, 0), pt[i], '0, 1, 1, "R2 ECB enc", ct[i]);
    for (int i = 0; i < 4; i++) begin
      run_block(mk(0, 0, 0, 2, 0, 0, 0), ct[i], '0, 1, 1, "R6 ECB dec", bk[i]);
      chk(bk[i] == pt[i], "R6 ECB round trip", bk[i], pt[i]);
    end

    // R3/R4/R5 CBC encrypt then decrypt
    load_iv(128'h00112233445566778899AABBCCDDEEFF);
    for (int i = 0; i < 4; i++) run_block(mk(0, 2, 2, 2, 1, 0, 0), pt[i], '0, i == 3, 1, "R3 CBC enc", ct[i]);
    for (int i = 0; i < 4; i++) begin
      run_block(mk(0, 3, 3, 2, 0, 0, 0), ct[i], '0, i == 3, 1, "R4 CBC dec", bk[i]);
      chk(bk[i] == pt[i], "R6 CBC round trip", bk[i], pt[i]);
    end

    // R5 IV source 1 continues the chain across messages
    run_block(mk(0, 2, 2, 2, 1, 0, 0), pt[0], '0, 1, 1, "R5 seed from IV reg", g);
    run_block(mk(0, 2, 2, 1, 1, 0, 0), pt[1], '0, 1, 1, "R5 kept vector", g1);
    chk(g1 == enc_f(pt[1] ^ g), "R5 continued chain", g1, enc_f(pt[1] ^ g));

    // R7 counter mode twice gives back the data
    load_iv(128'h1);
    for (int i = 0; i < 4; i++) run_block(mk(3, 3, 0, 2, 1, 1, 0), pt[i], '0, i == 3, 1, "R7 CTR pass 1", ct[i]);
    for (int i = 0; i < 4; i++) begin
      run_block(mk(3, 3, 0, 2, 1, 1, 0), ct[i], '0, i == 3, 1, "R7 CTR pass 2", bk[i]);
      chk(bk[i] == pt[i], "R7 CTR round trip", bk[i], pt[i]);
    end
    // R7 wrap of the counter, all-ones + 1 = 0
    load_iv('1);
    run_block(mk(3, 3, 0, 2, 1, 1, 0), '0, '0, 0, 1, "R7 wrap blk0", g);
    chk(g == enc_f('1), "R7 counter all ones", g, enc_f('1));
    run_block(mk(3, 3, 0, 2, 1, 1, 0), '0, '0, 1, 1, "R7 wrap blk1", g);
    chk(g == enc_f('0), "R7 counter wrapped to zero", g, enc_f('0));
    // R7 step of 5
    load_iv(128'h10);
    run_block(mk(3, 3, 0, 2, 1, 5, 0), '0, '0, 0, 1, "R7 step5 blk0", g);
    run_block(mk(3, 3, 0, 2, 1, 5, 0), '0, '0, 1, 1, "R7 step5 blk1", g);
    chk(g == enc_f(128'h15), "R7 step of five", g, enc_f(128'h15));

    // R3 tweaked mode, XOR both sides, round trip
    for (int i = 0; i < 2; i++) begin
      run_block(mk(0, 1, 1, 2, 1, 0, 0), pt[i], pt[3] + i, 1, 1, "R3 tweak enc", ct[i]);
      run_block(mk(0, 1, 1, 2, 0, 0, 0), ct[i], pt[3] + i, 1, 1, "R3 tweak dec", bk[i]);
      chk(bk[i] == pt[i], "R3 tweak round trip", bk[i], pt[i]);
    end

    // R8 chained MAC: only last block emitted
    load_iv('0);
    for (int i = 0; i < 3; i++) run_block(mk(0, 2, 2, 2, 1, 0, 1), pt[i], '0, i == 2, 1, "R8 MAC tag", g);
    chk(g == enc_f(pt[2] ^ enc_f(pt[1] ^ enc_f(pt[0]))), "R8 MAC value", g,
        enc_f(pt[2] ^ enc_f(pt[1] ^ enc_f(pt[0]))));

    // R2 feed previous core output, no XOR
    run_block(mk(2, 0, 0, 2, 1, 0, 0), pt[0], '0, 1, 1, "R2 prev output feed", g);

    // R5 random IV: two one-block messages differ
    run_block(mk(0, 2, 2, 3, 1, 0, 0), '0, '0, 1, 0, "R5 random", g1);
    run_block(mk(0, 2, 2, 3, 1, 0, 0), '0, '0, 1, 0, "R5 random", g2);
    chk(g1 != g2, "R5 random IV differs", g1, g2);
    m_prev = last_res; m_vec = last_res; m_first = 1'b1;

    // constrained random mix of modes
    for (int i = 0; i < 60; i++) begin
      int insel, ivs;
      insel = $urandom % 3; if (insel == 1) insel = 3;
      ivs = 1 + ($urandom % 2);
      if (i == 0) ivs = 2;
      if (($urandom % 8) == 0) load_iv({$urandom, $urandom, $urandom, $urandom});
      w = mk(insel, $urandom % 4, $urandom % 4, ivs, $urandom % 2, $urandom % 4, ($urandom % 4) == 0);
      run_block(w, {$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom},
                ($urandom % 3) == 0, 1, "R4 random mode mix", g);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule